// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management transactions towards an Ethernet PHY over a two-wire serial interface. The two wires are a management clock and a bidirectional data line. A host controls it through four small registers, picked by a 2-bit register select. The registers are:

- a PHY/register address with a direction flag,
- write data,
- read data,
- a control word that holds an enable flag and a start/busy status flag.

To run a transaction, the host first fills in the address and, for a write, the data. It then writes the control word with both the start flag and the enable flag set. The block shifts out one complete 64-bit frame. For a read, it captures the 16 bits that the PHY returns. When the frame ends, the block drops the status flag.

The management clock is the system clock divided by `2*HALF_DIV`. It rests low between frames. The block changes every outgoing bit after a falling edge of the management clock and samples incoming bits on its rising edge. Host reads are registered: `host_rdata` shows the register that `host_sel` selected in the previous cycle.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `mdc` is low and `mdio_oe` is low. Every host register reads as zero.
- R2: The address register (select 0) stores bits 10:0 of a write and reads back with the upper bits zero. In this register, bits 4:0 hold the register number, bits 9:5 hold the PHY address, and bit 10 selects the direction (1 = read, 0 = write).
- R3: The write-data register (select 1) stores bits 15:0 of a write and reads back with the upper bits zero.
- R4: A write to the control register (select 3) stores bit 3 as the enable flag. If that write has both bit 0 and bit 3 set while the block is idle, a frame starts. Control bit 0 then reads 1 from the next cycle until the frame ends. Control reads back as {enable in bit 3, busy in bit 0}.
- R5: Each frame drives 64 bits, MSB first, in this order: 32 ones, then 01, then opcode 10 (read) or 01 (write), then the PHY address, then the register number. A write frame continues with turnaround 10 and then the 16 data bits.
- R6: In a read frame, `mdio_oe` goes low for the two turnaround bits and the 16 data bits. The block samples `mdio_i` on each rising `mdc` edge of the data bits, MSB first. At the end of the frame the 16 bits appear in bits 15:0 of the read-data register (select 2).
- R7: `mdc` has a period of `2*HALF_DIV` system clocks. Its first rising edge comes `HALF_DIV` cycles after the start. A frame is exactly 64 `mdc` periods and ends on a falling edge. Outside a frame, `mdc` stays low.
- R8: A control write with bit 0 set and bit 3 clear sends no frame. `mdc` and `mdio_oe` stay low, and control bit 0 still reads 0.
- R9: While a frame runs, another start request is ignored. Writes to the address or write-data register do not change the bits of the frame already in flight.
- R10: Host writes to the read-data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select: 0 address, 1 write data, 2 read data, 3 control |
| host_wr | input | 1 | Write strobe for the selected register |
| host_wdata | input | HOST_W | Host write data |
| host_rdata | output | HOST_W | Registered read data of the register selected last cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven towards the PHY |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Serial data received from the PHY |

## Verification
The checker takes for granted that the host never pulses reset during a frame without also resetting the PHY side. It also assumes that `mdio_i` changes only while `mdc` is low, so that each rising edge sees a settled bit. The bench keeps to both assumptions. Its PHY model updates `mdio_i` at falling system-clock edges, based on the bit index it predicts from its own count of `mdc` half-periods. It also holds the line high whenever the block drives it. Host writes arrive away from the clock edge. Start requests during a frame and mid-frame register writes are sent on purpose to exercise the ignore rules.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;  // first turnaround bit index
  localparam int DATA_FIRST = 48;  // first data bit index
  localparam int DATA_BITS  = 16;
  localparam int ADDR_BITS  = 11;
  localparam int CTRL_GO    = 0;
  localparam int CTRL_EN    = 3;
  localparam int ADDR_OP    = 10;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_WDATA = 2'd1,
    SEL_RDATA = 2'd2,
    SEL_CTRL  = 2'd3
  } host_sel_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic rd, input logic [4:0] phy, input logic [4:0] rg,
    input logic [DATA_BITS-1:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
            (rd ? 2'b11 : 2'b10), (rd ? {DATA_BITS{1'b0}} : wd)};
  endfunction
endpackage

// File: rtl/mdc_tick_gen.sv
module mdc_tick_gen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == LAST);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 is_read,
  input  logic [4:0]           phy_addr,
  input  logic [4:0]           reg_addr,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [DATA_BITS-1:0] rd_word
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] IDX_LAST  = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] IDX_TA    = IW'(TA_FIRST);
  localparam logic [IW-1:0] IDX_DATA  = IW'(DATA_FIRST);

  logic [FRAME_BITS-1:0] shreg;
  logic [IW-1:0]         idx;
  logic [IW-1:0]         idx_nx;
  logic                  rd_op;
  logic [DATA_BITS-1:0]  cap;

  assign idx_nx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_word <= '0;
      shreg   <= '0;
      idx     <= '0;
      rd_op   <= 1'b0;
      cap     <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        rd_op   <= is_read;
        shreg   <= build_frame(is_read, phy_addr, reg_addr, wr_data);
        mdio_o  <= 1'b1;  // first preamble bit
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise && rd_op && (idx >= IDX_DATA))
        cap <= {cap[DATA_BITS-2:0], mdio_i};
      if (fall) begin
        if (idx == IDX_LAST) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
          if (rd_op) rd_word <= cap;
        end else begin
          idx     <= idx_nx;
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
          mdio_o  <= shreg[FRAME_BITS-2];
          mdio_oe <= !(rd_op && (idx_nx >= IDX_TA));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int HOST_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           host_sel,
  input  logic                 host_wr,
  input  logic [HOST_W-1:0]    host_wdata,
  input  logic                 busy,
  input  logic [DATA_BITS-1:0] rd_word,
  output logic [ADDR_BITS-1:0] addr_q,
  output logic [DATA_BITS-1:0] wdata_q,
  output logic                 start,
  output logic [HOST_W-1:0]    host_rdata
);
  logic en_q;
  logic ctrl_wr;

  assign ctrl_wr = host_wr && (host_sel == SEL_CTRL);
  assign start   = ctrl_wr && host_wdata[CTRL_GO] && host_wdata[CTRL_EN] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      wdata_q    <= '0;
      en_q       <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_wr && (host_sel == SEL_ADDR))  addr_q  <= host_wdata[ADDR_BITS-1:0];
      if (host_wr && (host_sel == SEL_WDATA)) wdata_q <= host_wdata[DATA_BITS-1:0];
      if (ctrl_wr) en_q <= host_wdata[CTRL_EN];
      case (host_sel)
        SEL_ADDR:  host_rdata <= HOST_W'(addr_q);
        SEL_WDATA: host_rdata <= HOST_W'(wdata_q);
        SEL_RDATA: host_rdata <= HOST_W'(rd_word);
        default:   host_rdata <= HOST_W'({en_q, 2'b00, busy});
      endcase
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 20,  // 100 MHz / (2*20) = 2.5 MHz
  parameter int HOST_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [ADDR_BITS-1:0] addr_q;
  logic [DATA_BITS-1:0] wdata_q;
  logic [DATA_BITS-1:0] rd_word;
  logic                 start_req;
  logic                 eng_busy;
  logic                 tick_rise;
  logic                 tick_fall;

  mdio_host_regs #(.HOST_W(HOST_W)) u_regs (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .busy(eng_busy), .rd_word(rd_word),
    .addr_q(addr_q), .wdata_q(wdata_q), .start(start_req),
    .host_rdata(host_rdata)
  );

  mdc_tick_gen #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .run(eng_busy),
    .mdc(mdc), .rise(tick_rise), .fall(tick_fall)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start(start_req),
    .is_read(addr_q[ADDR_OP]), .phy_addr(addr_q[9:5]), .reg_addr(addr_q[4:0]),
    .wr_data(wdata_q), .rise(tick_rise), .fall(tick_fall), .mdio_i(mdio_i),
    .busy(eng_busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_word(rd_word)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
  parameter int HOST_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        host_sel,
  input logic              host_wr,
  input logic [HOST_W-1:0] host_wdata,
  input logic              mdc,
  input logic              mdio_oe,
  input logic              eng_busy,
  input logic [15:0]       rd_word
);
  // R7: the management clock rests low outside a frame
  assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> !mdc);

  // R6: the data line is released as soon as a frame ends
  assert_release_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_busy) |-> !mdio_oe);

  // R8: a start with enable clear leaves the block idle
  assert_start_gated_R8: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel == 2'd3 && host_wdata[0] && !host_wdata[3] && !eng_busy)
      |=> !eng_busy);

  // R4: a frame begins only after a control write with the start flag
  assert_start_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(host_wr && host_sel == 2'd3 && host_wdata[0]));

  // R10: read data only moves at the end of a frame, never by a host write
  assert_rdata_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |=> $stable(rd_word));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.HOST_W(HOST_W)) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
  .host_wdata(host_wdata), .mdc(mdc), .mdio_oe(mdio_oe),
  .eng_busy(eng_busy), .rd_word(rd_word)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int H  = 2;
  localparam int HW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    host_sel = 2'd3;
  logic          host_wr = 1'b0;
  logic [HW-1:0] host_wdata = '0;
  logic [HW-1:0] host_rdata;
  logic          mdc, mdio_o, mdio_oe;
  logic          mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mdio_mgmt_master #(.HALF_DIV(H), .HOST_W(HW)) u_mdio_mgmt_master (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- behavioural reference model ----------------
  logic [10:0]   m_addr = '0;
  logic [15:0]   m_wdata = '0;
  logic [15:0]   m_rd = '0;
  logic          m_en = 1'b0;
  logic          m_busy = 1'b0;
  logic          m_rdop = 1'b0;
  logic [63:0]   m_frame = '0;
  logic [15:0]   m_phy = '0;
  logic [HW-1:0] exp_rdata = '0;
  logic [1:0]    m_sel_q = 2'd3;
  int            k = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_addr = '0; m_wdata = '0; m_rd = '0; m_en = 1'b0;
      m_busy = 1'b0; exp_rdata = '0; k = 0;
    end else begin
      logic old_busy;
      logic go;
      case (host_sel)
        2'd0: exp_rdata = HW'(m_addr);
        2'd1: exp_rdata = HW'(m_wdata);
        2'd2: exp_rdata = HW'(m_rd);
        default: exp_rdata = HW'({m_en, 2'b00, m_busy});
      endcase
      m_sel_q = host_sel;
      old_busy = m_busy;
      go = 1'b0;
      if (host_wr) begin
        if (host_sel == 2'd0) m_addr = host_wdata[10:0];
        if (host_sel == 2'd1) m_wdata = host_wdata[15:0];
        if (host_sel == 2'd3) begin
          m_en = host_wdata[3];
          go = host_wdata[0] && host_wdata[3];
        end
      end
      if (old_busy) begin
        k++;
        if (k == 128 * H) begin
          m_busy = 1'b0;
          if (m_rdop) m_rd = m_phy;
        end
      end
      if (go && !old_busy) begin
        m_busy = 1'b1;
        k = 0;
        m_rdop = m_addr[10];
        m_frame = {32'hFFFF_FFFF, 2'b01, (m_rdop ? 2'b10 : 2'b01), m_addr[9:5],
                   m_addr[4:0], (m_rdop ? 2'b11 : 2'b10),
                   (m_rdop ? 16'h0000 : m_wdata)};
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison and PHY model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int bitn;
      logic e_mdc, e_oe, e_o;
      bitn  = m_busy ? k / (2 * H) : 0;
      e_mdc = m_busy ? (((k / H) % 2) == 1) : 1'b0;
      e_oe  = m_busy ? !(m_rdop && bitn >= 46) : 1'b0;
      e_o   = m_busy ? m_frame[63 - bitn] : 1'b0;
      check(mdc == e_mdc, "R7 mdc", mdc, e_mdc);
      check(mdio_oe == e_oe, e_oe ? "R5 oe" : "R6 oe", mdio_oe, e_oe);
      if (e_oe) check(mdio_o == e_o, "R5 bit", mdio_o, e_o);
      case (m_sel_q)
        2'd0: check(host_rdata == exp_rdata, "R2 rdata", host_rdata, exp_rdata);
        2'd1: check(host_rdata == exp_rdata, "R3 rdata", host_rdata, exp_rdata);
        2'd2: check(host_rdata == exp_rdata, "R6 rdata", host_rdata, exp_rdata);
        default: check(host_rdata == exp_rdata, "R4 rdata", host_rdata, exp_rdata);
      endcase
      mdio_i <= (m_busy && m_rdop && bitn >= 48) ? m_phy[63 - bitn] : 1'b1;
    end
  end

  task automatic hwrite(input logic [1:0] s, input logic [HW-1:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] s, output logic [HW-1:0] d);
    @(negedge clk);
    host_sel = s;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [HW-1:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {mdc, mdio_oe}, 0);
    for (int s = 0; s < 4; s++) begin
      hread(2'(s), v);
      check(v == '0, "R1 reg", v, 0);
    end
    // R2, R3: masking of stored fields
    hwrite(2'd0, 32'hFFFF_FFFF);
    hread(2'd0, v); check(v == 32'h7FF, "R2", v, 32'h7FF);
    hwrite(2'd1, 32'hFFFF_FFFF);
    hread(2'd1, v); check(v == 32'hFFFF, "R3", v, 32'hFFFF);
    // R10: read-data register not writable
    hwrite(2'd2, 32'h1234_5678);
    hread(2'd2, v); check(v == 32'h0, "R10", v, 0);
    // R8: start with enable clear
    hwrite(2'd3, 32'h1);
    hread(2'd3, v); check(v == 32'h0, "R8", v, 0);
    repeat (3 * H) @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 pins", {mdc, mdio_oe}, 0);
    // write frame: phy 5, reg 0x12
    hwrite(2'd0, {21'd0, 1'b0, 5'd5, 5'h12});
    hwrite(2'd1, 32'hA5C3);
    hwrite(2'd3, 32'h9);
    hread(2'd3, v); check(v == 32'h9, "R4 busy", v, 32'h9);
    // R9: retrigger and register edits during the frame
    hwrite(2'd3, 32'h9);
    hwrite(2'd0, {21'd0, 1'b1, 5'd3, 5'h07});
    hwrite(2'd1, 32'h0F0F);
    hread(2'd3, v); check(v == 32'h9, "R9 still busy", v, 32'h9);
    wait_idle();
    hread(2'd3, v); check(v == 32'h8, "R4 done", v, 32'h8);
    // read frame, pattern 1
    m_phy = 16'h1808;
    hwrite(2'd0, {21'd0, 1'b1, 5'd31, 5'd1});
    hwrite(2'd3, 32'h9);
    wait_idle();
    hread(2'd2, v); check(v == 32'h1808, "R6 read", v, 32'h1808);
    // read frame, pattern 2
    m_phy = 16'h5A3C;
    hwrite(2'd0, {21'd0, 1'b1, 5'd10, 5'd21});
    hwrite(2'd3, 32'hF);
    wait_idle();
    hread(2'd2, v); check(v == 32'h5A3C, "R6 read2", v, 32'h5A3C);
    // write frame, all-ones fields, then R10 again
    hwrite(2'd0, {21'd0, 1'b0, 5'd31, 5'd31});
    hwrite(2'd1, 32'hFFFF);
    hwrite(2'd3, 32'h9);
    wait_idle();
    hwrite(2'd2, 32'h0);
    hread(2'd2, v); check(v == 32'h5A3C, "R10 after", v, 32'h5A3C);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule